// File: doc/BRIEF.md
# Debug Trigger Sequencer

This block sits beside a set of instruction-address comparators in an on-chip debug unit. Each comparator reports a match for an executed instruction. The sequencer turns those matches into qualified events, then steps a small state machine through a programmed pattern. When the pattern completes, it raises a one-cycle trigger. Three patterns can be selected:

- an ordered pair of events;
- an immediate trigger on any selected event;
- a check that two events strictly take turns.

A range option joins comparators 0 and 1 into a single address window. With this option on, the event from comparator 0 means that execution has entered the window, and comparator 1 produces no events of its own. Software arms the sequencer and can disarm it. The current state is visible on a 2-bit status output. The scenario, range and control inputs should stay stable while the sequencer is armed.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset, `state_o` is 2'b00 (disarmed) and `trig_o` is 0. The state encoding is 00 disarmed, 01 first state, 10 second state, 11 final state.
- R2: An `arm_i` pulse puts the state at 01 on the next cycle, and any events in that cycle are ignored. A `disarm_i` pulse puts the state at 00 on the next cycle. If both are high together, the disarm wins.
- R3: Each control field holds a comparator mask in bits [2:0] (bit i selects comparator i) and a combine bit in bit 3. With bit 3 at 0, any selected event matches. With bit 3 at 1, every selected event must occur in the same cycle. A zero mask never matches. `ctl_one_i` defines event A and `ctl_two_i` defines event B.
- R4: With `scen_i`=00 (sequence), event A moves the first state to the second state. Event B then moves the second state to the final state.
- R5: With `scen_i`=01 (immediate), event A moves the first state directly to the final state.
- R6: With `scen_i`=10 (alternation check), the machine moves as follows:
  - first state with event A: go to the second state;
  - first state with event B: go to the final state;
  - second state with event B: go back to the first state;
  - second state with event A: go to the final state.
- R7: When both events occur in one cycle, the event that the current state expects wins. The state advances by at most one step per cycle, so in the sequence scenario the first state never reaches the final state in one cycle.
- R8: While `range_en_i` is 1, the comparator-0 event is the first cycle of a high run on `match_i[0]` (entry into the window), and `match_i[1]` produces no event.
- R9: `trig_o` is high for exactly the one cycle in which `state_o` first shows 11.
- R10: In the final state, events are ignored and the state holds at 11 until `arm_i` or `disarm_i`.
- R11: In the disarmed state, and with `scen_i`=11 (reserved), events cause no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm_i | input | 1 | Arm pulse; restarts the machine at the first state |
| disarm_i | input | 1 | Disarm pulse; returns the machine to the disarmed state |
| range_en_i | input | 1 | Pairs comparators 0 and 1 into a window |
| scen_i | input | 2 | Scenario: 00 sequence, 01 immediate, 10 alternation, 11 reserved |
| ctl_one_i | input | NUM_CMP+1 (4) | Event A selection (mask and combine bit) |
| ctl_two_i | input | NUM_CMP+1 (4) | Event B selection (mask and combine bit) |
| match_i | input | NUM_CMP (3) | Per-comparator match indications |
| state_o | output | 2 | Current state |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The in-line assertions check, on every cycle, these properties:
- the trigger is a single pulse and appears only in the final state;
- the final and disarmed states hold when there is no control pulse;
- disarm takes priority;
- the sequence scenario never skips the second state;
- in range mode, two entry events never occur back to back.

The bench scenarios are what show the pattern logic itself:
- which state each scenario reaches for given events;
- how the control fields combine matches;
- which event wins when both occur in one cycle;
- that comparator 1 is muted in range mode.

These outputs are compared against a reference model computed in the bench.

// File: rtl/dts_pkg.sv
package dts_pkg;

  typedef enum logic [1:0] {
    ST_OFF = 2'b00,
    ST_ONE = 2'b01,
    ST_TWO = 2'b10,
    ST_FIN = 2'b11
  } dts_state_e;

  typedef enum logic [1:0] {
    SC_SEQ  = 2'b00,
    SC_IMM  = 2'b01,
    SC_ORD  = 2'b10,
    SC_NONE = 2'b11
  } dts_scen_e;

endpackage

// File: rtl/dts_rst_sync.sv
module dts_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/dts_event_qual.sv
module dts_event_qual #(
  parameter int NUM_CMP = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               range_en_i,
  input  logic [NUM_CMP-1:0] match_i,
  output logic [NUM_CMP-1:0] ev_o
);

  // level of comparator 0 in the previous cycle, used for window entry
  logic m0_prev_q;
  logic m0_prev_en;

  assign m0_prev_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          m0_prev_q <= 1'b0;
    else if (m0_prev_en) m0_prev_q <= match_i[0];
  end

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_ev
    if (gi == 0) begin : g_lo
      assign ev_o[gi] = range_en_i ? (match_i[gi] & ~m0_prev_q) : match_i[gi];
    end else if (gi == 1) begin : g_hi
      assign ev_o[gi] = range_en_i ? 1'b0 : match_i[gi];
    end else begin : g_plain
      assign ev_o[gi] = match_i[gi];
    end
  end

  AST_ENTRY_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (range_en_i && ev_o[0]) |=> !(range_en_i && ev_o[0])); // R8

endmodule

// File: rtl/dts_sel.sv
module dts_sel #(
  parameter int NUM_CMP = 3,
  localparam int CTL_W  = NUM_CMP + 1
) (
  input  logic [CTL_W-1:0]   ctl_i,
  input  logic [NUM_CMP-1:0] ev_i,
  output logic               hit_o
);

  logic [NUM_CMP-1:0] mask;
  logic               need_all;
  logic [NUM_CMP-1:0] seen;

  always_comb begin
    mask     = ctl_i[NUM_CMP-1:0];
    need_all = ctl_i[NUM_CMP];
    seen     = ev_i & mask;
    if (mask == '0)    hit_o = 1'b0;
    else if (need_all) hit_o = (seen == mask);
    else               hit_o = |seen;
  end

endmodule

// File: rtl/dts_fsm.sv
module dts_fsm
  import dts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_i,
  input  logic       disarm_i,
  input  logic [1:0] scen_i,
  input  logic       hit_a_i,
  input  logic       hit_b_i,
  output logic [1:0] state_o,
  output logic       trig_o
);

  dts_state_e state_q, state_d;
  logic       state_en;
  logic       trig_q, trig_d;

  always_comb begin
    state_d = state_q;
    if (disarm_i) begin
      state_d = ST_OFF;
    end else if (arm_i) begin
      state_d = ST_ONE;
    end else begin
      unique case (state_q)
        ST_ONE: begin
          unique case (scen_i)
            SC_SEQ:  if (hit_a_i) state_d = ST_TWO;
            SC_IMM:  if (hit_a_i) state_d = ST_FIN;
            SC_ORD: begin
              if (hit_a_i)      state_d = ST_TWO;
              else if (hit_b_i) state_d = ST_FIN;
            end
            default: state_d = state_q;
          endcase
        end
        ST_TWO: begin
          unique case (scen_i)
            SC_SEQ:  if (hit_b_i) state_d = ST_FIN;
            SC_ORD: begin
              if (hit_b_i)      state_d = ST_ONE;
              else if (hit_a_i) state_d = ST_FIN;
            end
            default: state_d = state_q;
          endcase
        end
        default: state_d = state_q;
      endcase
    end
  end

  assign state_en = arm_i | disarm_i | (state_q == ST_ONE) | (state_q == ST_TWO);
  assign trig_d   = (state_d == ST_FIN) && (state_q != ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_OFF;
    else if (state_en) state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end

  assign state_o = state_q;
  assign trig_o  = trig_q;

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q); // R9
  AST_TRIG_IN_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> (state_q == ST_FIN)); // R9
  AST_FINAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN && !arm_i && !disarm_i) |=> (state_q == ST_FIN)); // R10
  AST_DISARM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_i |=> (state_q == ST_OFF)); // R2
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && !arm_i) |=> (state_q == ST_OFF)); // R11
  AST_SEQ_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ONE && scen_i == SC_SEQ && !arm_i && !disarm_i)
      |=> (state_q != ST_FIN)); // R7

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq #(
  parameter int NUM_CMP = 3,
  localparam int CTL_W  = NUM_CMP + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_i,
  input  logic               disarm_i,
  input  logic               range_en_i,
  input  logic [1:0]         scen_i,
  input  logic [CTL_W-1:0]   ctl_one_i,
  input  logic [CTL_W-1:0]   ctl_two_i,
  input  logic [NUM_CMP-1:0] match_i,
  output logic [1:0]         state_o,
  output logic               trig_o
);

  logic               rst_n_sync;
  logic [NUM_CMP-1:0] ev;
  logic               hit_a;
  logic               hit_b;

  dts_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_sync)
  );

  dts_event_qual #(.NUM_CMP(NUM_CMP)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .range_en_i (range_en_i),
    .match_i    (match_i),
    .ev_o       (ev)
  );

  dts_sel #(.NUM_CMP(NUM_CMP)) u_sel_a (
    .ctl_i (ctl_one_i),
    .ev_i  (ev),
    .hit_o (hit_a)
  );

  dts_sel #(.NUM_CMP(NUM_CMP)) u_sel_b (
    .ctl_i (ctl_two_i),
    .ev_i  (ev),
    .hit_o (hit_b)
  );

  dts_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .arm_i    (arm_i),
    .disarm_i (disarm_i),
    .scen_i   (scen_i),
    .hit_a_i  (hit_a),
    .hit_b_i  (hit_b),
    .state_o  (state_o),
    .trig_o   (trig_o)
  );

endmodule

// File: tb/dbg_trig_seq_bench.sv
module dbg_trig_seq_bench;

  logic       clk;
  logic       rst_n;
  logic       arm, disarm, range_en;
  logic [1:0] scen;
  logic [3:0] ctl1, ctl2;
  logic [2:0] match;
  logic [1:0] state;
  logic       trig;

  int   checks;
  int   errors;
  logic [1:0] exp_st;
  logic       exp_trig;
  logic       m0_prev;
  string      tag;

  dbg_trig_seq u_dbg_trig_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm),
    .disarm_i   (disarm),
    .range_en_i (range_en),
    .scen_i     (scen),
    .ctl_one_i  (ctl1),
    .ctl_two_i  (ctl2),
    .match_i    (match),
    .state_o    (state),
    .trig_o     (trig)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Event qualification per R8
  function automatic logic [2:0] qual(input logic [2:0] m, input logic r, input logic p);
    logic [2:0] e;
    e[0] = r ? (m[0] & ~p) : m[0];
    e[1] = r ? 1'b0 : m[1];
    e[2] = m[2];
    return e;
  endfunction

  // Control field decode per R3
  function automatic logic sel(input logic [3:0] c, input logic [2:0] e);
    if (c[2:0] == 3'b000) return 1'b0;
    if (c[3]) return ((e & c[2:0]) == c[2:0]);
    return |(e & c[2:0]);
  endfunction

  // State transitions per R2, R4, R5, R6, R7, R10, R11
  function automatic logic [1:0] nxt(input logic [1:0] s, input logic a_m, input logic d_m,
                                     input logic [1:0] sc, input logic ha, input logic hb);
    if (d_m) return 2'b00;
    if (a_m) return 2'b01;
    if (s == 2'b01) begin
      if (sc == 2'b00 && ha) return 2'b10;
      if (sc == 2'b01 && ha) return 2'b11;
      if (sc == 2'b10) begin
        if (ha) return 2'b10;
        if (hb) return 2'b11;
      end
    end else if (s == 2'b10) begin
      if (sc == 2'b00 && hb) return 2'b11;
      if (sc == 2'b10) begin
        if (hb) return 2'b01;
        if (ha) return 2'b11;
      end
    end
    return s;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // one clock: model update, edge, compare at the falling edge
  task automatic tick();
    logic [2:0] e;
    logic [1:0] ns;
    e  = qual(match, range_en, m0_prev);
    ns = nxt(exp_st, arm, disarm, scen, sel(ctl1, e), sel(ctl2, e));
    exp_trig = (ns == 2'b11) && (exp_st != 2'b11);
    exp_st   = ns;
    m0_prev  = match[0];
    @(posedge clk);
    @(negedge clk);
    chk(state == exp_st, {tag, " state"}, int'(state), int'(exp_st));
    chk(trig == exp_trig, {tag, " trig R9"}, int'(trig), int'(exp_trig));
  endtask

  task automatic idle();
    arm = 0; disarm = 0; match = 3'b000;
  endtask

  task automatic expect_st(input logic [1:0] s, input logic t, input string req);
    chk(state == s, req, int'(state), int'(s));
    chk(trig == t, {req, " trig"}, int'(trig), int'(t));
  endtask

  task automatic do_arm();
    idle(); arm = 1; tick(); arm = 0;
    expect_st(2'b01, 1'b0, "R2 arm");
  endtask

  task automatic ev(input logic [2:0] m);
    match = m; tick(); match = 3'b000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    exp_st = 2'b00; exp_trig = 1'b0; m0_prev = 1'b0;
    tag = "R1";
    rst_n = 0; idle(); range_en = 0; scen = 2'b00; ctl1 = 4'h0; ctl2 = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    expect_st(2'b00, 1'b0, "R1 reset");

    // R11: disarmed ignores events
    tag = "R11"; scen = 2'b01; ctl1 = 4'b0111;
    ev(3'b111);
    expect_st(2'b00, 1'b0, "R11 off ignores");

    // R2: arm, disarm, both
    tag = "R2";
    do_arm();
    disarm = 1; tick(); disarm = 0;
    expect_st(2'b00, 1'b0, "R2 disarm");
    arm = 1; disarm = 1; tick(); idle();
    expect_st(2'b00, 1'b0, "R2 disarm wins");

    // R3 + R5: all-of mask in immediate scenario
    tag = "R3"; scen = 2'b01; ctl1 = 4'b1101;
    do_arm();
    ev(3'b001);
    expect_st(2'b01, 1'b0, "R3 partial all-of");
    ev(3'b101);
    expect_st(2'b11, 1'b1, "R3 R5 all-of fires");
    tag = "R10";
    ev(3'b111);
    expect_st(2'b11, 1'b0, "R10 final holds R9 single pulse");
    tag = "R3"; ctl1 = 4'b0000;
    do_arm();
    ev(3'b111);
    expect_st(2'b01, 1'b0, "R3 zero mask");
    tag = "R5"; ctl1 = 4'b0110;
    ev(3'b100);
    expect_st(2'b11, 1'b1, "R5 any-of immediate");

    // R4: sequence
    tag = "R4"; scen = 2'b00; ctl1 = 4'b0001; ctl2 = 4'b0100;
    do_arm();
    ev(3'b100);
    expect_st(2'b01, 1'b0, "R4 B first ignored");
    ev(3'b001);
    expect_st(2'b10, 1'b0, "R4 A advances");
    ev(3'b001);
    expect_st(2'b10, 1'b0, "R4 A again holds");
    ev(3'b100);
    expect_st(2'b11, 1'b1, "R4 B fires");

    // R7: both in one cycle, sequence
    tag = "R7";
    do_arm();
    ev(3'b101);
    expect_st(2'b10, 1'b0, "R7 one step");

    // R6: alternation
    tag = "R6"; scen = 2'b10; ctl1 = 4'b0001; ctl2 = 4'b0010;
    do_arm();
    ev(3'b001); expect_st(2'b10, 1'b0, "R6 A");
    ev(3'b010); expect_st(2'b01, 1'b0, "R6 B back");
    ev(3'b001); expect_st(2'b10, 1'b0, "R6 A again");
    ev(3'b001); expect_st(2'b11, 1'b1, "R6 double A");
    do_arm();
    ev(3'b010); expect_st(2'b11, 1'b1, "R6 B first");
    tag = "R7";
    do_arm();
    ev(3'b011); expect_st(2'b10, 1'b0, "R7 alt expected A wins");
    ev(3'b011); expect_st(2'b01, 1'b0, "R7 alt expected B wins");

    // R8: range mode
    tag = "R8"; scen = 2'b00; range_en = 1; ctl1 = 4'b0010; ctl2 = 4'b0001;
    do_arm();
    ev(3'b010); expect_st(2'b01, 1'b0, "R8 M1 muted");
    ctl1 = 4'b0001;
    match = 3'b001; tick();
    expect_st(2'b10, 1'b0, "R8 entry");
    tick();
    expect_st(2'b10, 1'b0, "R8 inside no event");
    match = 3'b000; tick();
    match = 3'b001; tick(); match = 3'b000;
    expect_st(2'b11, 1'b1, "R8 re-entry");
    range_en = 0;

    // R11: reserved scenario
    tag = "R11"; scen = 2'b11; ctl1 = 4'b0111; ctl2 = 4'b0111;
    do_arm();
    ev(3'b111); expect_st(2'b01, 1'b0, "R11 reserved");

    // random phase, checked against the model every cycle
    tag = "RND";
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      arm    = ($urandom_range(15) == 0);
      disarm = ($urandom_range(63) == 0);
      if ($urandom_range(31) == 0) scen = 2'($urandom_range(3));
      if ($urandom_range(31) == 0) ctl1 = 4'($urandom_range(15));
      if ($urandom_range(31) == 0) ctl2 = 4'($urandom_range(15));
      if ($urandom_range(63) == 0) range_en = ~range_en;
      for (int b = 0; b < 3; b++) match[b] = ($urandom_range(3) == 0);
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule